// File: doc/BRIEF.md
# Expedited Scan-Out Response Compactor

This block sits between segmented scan chains and the tester-facing scan output. Every chain is cut into equal segments, and the tail bit of each segment is tapped. One chain is set aside as a buffer. During the first block of shift cycles, the block XORs every segment tap of every chain into one compacted bit per cycle. It writes that bit into the last segment of the buffer chain. At the same time it feeds zeros into every other segment input. By the end of the first block all response data has therefore been folded into the buffer's last segment, and all other chains hold only zeros.

During the remaining blocks the buffer chain shifts as one ordinary chain. Its tail is passed to the scan output, so the compacted bits leave first and constant zeros follow. Every non-buffer chain shifts only zeros after the first block. This cuts scan-out switching without any filling of unknown stimulus bits.

A start pulse arms the unload. Each cycle with shift enable set advances it by one shift. After chain-length shifts a done flag rises and the block returns to idle. The chain length must be a multiple of the block count.

Top module: `xpd_resp_compactor`

## Requirements
- R1: After reset, `done`, `cmp_bit` and `scan_out` are 0 and every bit of `seg_fill` is 0.
- R2: While in the first block of an armed unload, `cmp_bit` equals the XOR of all `NUM_CHAINS*NUM_BLOCKS` bits of `seg_tap`, and `scan_out` is 0. Tap index c*NUM_BLOCKS+k is segment k of chain c, where segment NUM_BLOCKS-1 holds the chain tail.
- R3: While in the first block, fill bit BUF_CHAIN*NUM_BLOCKS+NUM_BLOCKS-1 (the buffer chain's last segment input) equals `cmp_bit`, and every other `seg_fill` bit is 0.
- R4: In blocks 1 to NUM_BLOCKS-1, `scan_out` equals the buffer tail tap BUF_CHAIN*NUM_BLOCKS+NUM_BLOCKS-1, and `cmp_bit` is 0 whatever the taps are.
- R5: In blocks 1 to NUM_BLOCKS-1, buffer segment k>0 is filled from buffer tap k-1, buffer segment 0 is filled with 0, and every non-buffer fill is 0.
- R6: The unload advances only in cycles with `shift_en` high. With `shift_en` low the block stays in its current block of cycles.
- R7: `done` rises after exactly CHAIN_LEN shifts following `start` and holds until the next `start`. While idle, `cmp_bit`, `scan_out` and `seg_fill` are all 0.
- R8: `start` restarts the unload from shift 0 and clears `done`, also in the middle of an unload. A shift in the cycle of `start` is not counted.
- R9: With the chains connected, the `scan_out` stream over a full unload is 0 in the first block. In shift S+j of the second block (S = CHAIN_LEN/NUM_BLOCKS) it is the XOR of the bits that sat j places before the tail of every segment at load time, and it is 0 afterwards. All chains hold zeros at the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms a new unload |
| shift_en | input | 1 | Scan shift enable; one shift per high cycle |
| seg_tap | input | NUM_CHAINS*NUM_BLOCKS | Tail bit of every chain segment |
| seg_fill | output | NUM_CHAINS*NUM_BLOCKS | Serial input of every chain segment |
| cmp_bit | output | 1 | Compacted XOR bit |
| scan_out | output | 1 | Serial response stream to the tester |
| done | output | 1 | Unload finished |

## Verification
In the first block, with the counter paused, all 4096 tap patterns are swept. This tells a full XOR apart from one that drops or doubles a tap, and it checks that only the buffer tail fill carries the result. The same sweep in a drain block shows whether scan output follows only the buffer tail and whether the buffer segments link correctly. End-to-end unloads through a bench model of the chains use all-zero, all-one, walking-one and pseudo-random loads. They separate correct segment ordering and block timing from off-by-one block boundaries. Pauses and mid-unload restarts show whether counting is tied to shift enable and start.

// File: rtl/xpd_pkg.sv
package xpd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_COMPACT = 2'd1,
    PH_DRAIN   = 2'd2
  } xpd_phase_e;
endpackage

// File: rtl/xpd_rst_sync.sv
module xpd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/xpd_seq.sv
module xpd_seq
  import xpd_pkg::*;
#(
  parameter int CHAIN_LEN  = 12,
  parameter int NUM_BLOCKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       shift_en,
  output xpd_phase_e phase,
  output logic       done
);
  localparam int SEG_LEN = CHAIN_LEN / NUM_BLOCKS;
  localparam int SEG_W   = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;
  localparam int BLK_W   = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(SEG_LEN - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(NUM_BLOCKS - 1);

  logic             active_q, active_d;
  logic             done_q,   done_d;
  logic [SEG_W-1:0] seg_q,    seg_d;
  logic [BLK_W-1:0] blk_q,    blk_d;
  logic             step;

  assign step = active_q && shift_en;

  always_comb begin
    active_d = active_q;
    done_d   = done_q;
    seg_d    = seg_q;
    blk_d    = blk_q;
    if (start) begin
      active_d = 1'b1;
      done_d   = 1'b0;
      seg_d    = '0;
      blk_d    = '0;
    end else if (step) begin
      if (seg_q == SEG_LAST) begin
        seg_d = '0;
        if (blk_q == BLK_LAST) begin
          active_d = 1'b0;
          done_d   = 1'b1;
          blk_d    = '0;
        end else begin
          blk_d = blk_q + 1'b1;
        end
      end else begin
        seg_d = seg_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      seg_q    <= '0;
      blk_q    <= '0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      seg_q    <= seg_d;
      blk_q    <= blk_d;
    end
  end

  always_comb begin
    if (!active_q)        phase = PH_IDLE;
    else if (blk_q == '0) phase = PH_COMPACT;
    else                  phase = PH_DRAIN;
  end

  assign done = done_q;

  // R8: start always re-arms from shift zero
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active_q && !done_q && seg_q == '0 && blk_q == '0));

  // R6: without shift enable the position is held
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !shift_en) |=> ($stable(seg_q) && $stable(blk_q) && $stable(done_q)));

  // R7: done and an active unload never overlap
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !active_q);

  // R7: done only rises on the last shift of the last block
  a_r7_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(shift_en && blk_q == BLK_LAST && seg_q == SEG_LAST));
endmodule

// File: rtl/xpd_xor_tree.sv
module xpd_xor_tree #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH-1:0] vec,
  output logic             par
);
  logic [WIDTH:0] acc;

  assign acc[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_acc
    assign acc[i+1] = acc[i] ^ vec[i];
  end

  assign par = acc[WIDTH];
endmodule

// File: rtl/xpd_fill_route.sv
module xpd_fill_route
  import xpd_pkg::*;
#(
  parameter int NUM_BLOCKS = 3
) (
  input  xpd_phase_e            phase,
  input  logic                  cmp_bit,
  input  logic [NUM_BLOCKS-1:0] buf_tap,
  output logic [NUM_BLOCKS-1:0] buf_fill,
  output logic                  scan_out
);
  logic in_compact;
  logic in_drain;

  assign in_compact = (phase == PH_COMPACT);
  assign in_drain   = (phase == PH_DRAIN);

  for (genvar k = 0; k < NUM_BLOCKS; k++) begin : g_seg
    if (k == NUM_BLOCKS - 1 && k == 0) begin : g_only
      assign buf_fill[k] = in_compact & cmp_bit;
    end else if (k == NUM_BLOCKS - 1) begin : g_last
      assign buf_fill[k] = in_compact ? cmp_bit : (in_drain & buf_tap[k-1]);
    end else if (k == 0) begin : g_head
      assign buf_fill[k] = 1'b0;
    end else begin : g_mid
      assign buf_fill[k] = in_drain & buf_tap[k-1];
    end
  end

  assign scan_out = in_drain & buf_tap[NUM_BLOCKS-1];
endmodule

// File: rtl/xpd_resp_compactor.sv
module xpd_resp_compactor
  import xpd_pkg::*;
#(
  parameter int NUM_CHAINS = 4,
  parameter int CHAIN_LEN  = 12,
  parameter int NUM_BLOCKS = 3,
  parameter int BUF_CHAIN  = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           shift_en,
  input  logic [NUM_CHAINS*NUM_BLOCKS-1:0] seg_tap,
  output logic [NUM_CHAINS*NUM_BLOCKS-1:0] seg_fill,
  output logic                           cmp_bit,
  output logic                           scan_out,
  output logic                           done
);
  localparam int NUM_TAPS = NUM_CHAINS * NUM_BLOCKS;
  localparam int BUF_BASE = BUF_CHAIN * NUM_BLOCKS;
  localparam int BUF_TAIL = BUF_BASE + NUM_BLOCKS - 1;

  logic                  rst_sync_n;
  xpd_phase_e            phase;
  logic                  par;
  logic [NUM_BLOCKS-1:0] buf_fill;

  xpd_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xpd_seq #(
    .CHAIN_LEN  (CHAIN_LEN),
    .NUM_BLOCKS (NUM_BLOCKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .shift_en (shift_en),
    .phase    (phase),
    .done     (done)
  );

  xpd_xor_tree #(
    .WIDTH (NUM_TAPS)
  ) u_xor (
    .vec (seg_tap),
    .par (par)
  );

  assign cmp_bit = (phase == PH_COMPACT) & par;

  xpd_fill_route #(
    .NUM_BLOCKS (NUM_BLOCKS)
  ) u_route (
    .phase    (phase),
    .cmp_bit  (cmp_bit),
    .buf_tap  (seg_tap[BUF_BASE +: NUM_BLOCKS]),
    .buf_fill (buf_fill),
    .scan_out (scan_out)
  );

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    if (c == BUF_CHAIN) begin : g_buf
      assign seg_fill[c*NUM_BLOCKS +: NUM_BLOCKS] = buf_fill;
    end else begin : g_zero
      assign seg_fill[c*NUM_BLOCKS +: NUM_BLOCKS] = '0;
    end
  end

  // R2: tester stream stays quiet while compacting
  a_r2_quiet_out: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_COMPACT) |-> !scan_out);

  // R4: compacted bit only appears in the first block
  a_r4_gate_cmp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase != PH_COMPACT) |-> !cmp_bit);

  // R3: compacted bit is what enters the buffer tail segment
  a_r3_buf_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_COMPACT) |-> (seg_fill[BUF_TAIL] == cmp_bit));

  // R7: nothing toggles toward the chains while idle
  a_r7_idle_fill: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_IDLE) |-> (seg_fill == '0 && !scan_out));
endmodule

// File: tb/xpd_resp_compactor_bench.sv
module xpd_resp_compactor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int L    = 12;
  localparam int B    = 3;
  localparam int BUFC = 0;
  localparam int S    = L / B;
  localparam int T    = N * B;
  localparam int TAIL = BUFC * B + B - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         shift_en;
  logic [T-1:0] sweep_tap;
  logic [T-1:0] model_tap;
  logic [T-1:0] seg_tap;
  logic [T-1:0] seg_fill;
  logic         cmp_bit;
  logic         scan_out;
  logic         done;
  logic         model_en;

  logic [L-1:0] chn  [N];
  logic [L-1:0] orig [N];

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [31:0] lfsr = 32'h1d2c_3b4a;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < N; c++)
      for (int k = 0; k < B; k++)
        model_tap[c*B+k] = chn[c][k*S+S-1];
  end

  assign seg_tap = model_en ? model_tap : sweep_tap;

  xpd_resp_compactor #(
    .NUM_CHAINS (N), .CHAIN_LEN (L), .NUM_BLOCKS (B), .BUF_CHAIN (BUFC)
  ) u_xpd_resp_compactor (
    .clk (clk), .rst_n (rst_n), .start (start), .shift_en (shift_en),
    .seg_tap (seg_tap), .seg_fill (seg_fill), .cmp_bit (cmp_bit),
    .scan_out (scan_out), .done (done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic shift(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); shift_en = 1'b1;
      @(posedge clk); #1 shift_en = 1'b0;
    end
  endtask

  function automatic logic [T-1:0] fill_compact(input logic [T-1:0] v);
    logic [T-1:0] f = '0;
    f[TAIL] = $countones(v) % 2;
    return f;
  endfunction

  function automatic logic [T-1:0] fill_drain(input logic [T-1:0] v);
    logic [T-1:0] f = '0;
    for (int k = 1; k < B; k++) f[BUFC*B+k] = v[BUFC*B+k-1];
    return f;
  endfunction

  task automatic sweep_compact(input string req);
    for (int v = 0; v < (1 << T); v++) begin
      @(negedge clk); sweep_tap = T'(v); #1;
      chk(cmp_bit == ($countones(T'(v)) % 2) && !scan_out && seg_fill == fill_compact(T'(v)),
          req, {cmp_bit, scan_out, 2'b00, seg_fill}, {1'($countones(T'(v)) % 2), 3'b000, fill_compact(T'(v))});
    end
  endtask

  task automatic sweep_drain(input string req);
    for (int v = 0; v < (1 << T); v++) begin
      @(negedge clk); sweep_tap = T'(v); #1;
      chk(scan_out == v[TAIL] && !cmp_bit && seg_fill == fill_drain(T'(v)),
          req, {cmp_bit, scan_out, 2'b00, seg_fill}, {1'b0, 1'(v[TAIL]), 2'b00, fill_drain(T'(v))});
    end
  endtask

  task automatic run_e2e(input string tag);
    logic [L-1:0] nxt [N];
    logic [S-1:0] cexp;
    logic         e;
    logic [T-1:0] f;
    for (int j = 0; j < S; j++) begin
      e = 1'b0;
      for (int c = 0; c < N; c++)
        for (int k = 0; k < B; k++) e ^= orig[c][k*S+S-1-j];
      cexp[j] = e;
    end
    for (int c = 0; c < N; c++) chn[c] = orig[c];
    model_en = 1'b1;
    pulse_start();
    for (int t = 0; t < L; t++) begin
      @(negedge clk); shift_en = 1'b1; #1;
      e = (t >= S && t < 2*S) ? cexp[t-S] : 1'b0;
      chk(scan_out == e, {"R9 stream ", tag}, 32'(scan_out), 32'(e));
      f = seg_fill;
      for (int c = 0; c < N; c++)
        for (int p = 0; p < L; p++)
          nxt[c][p] = (p % S == 0) ? f[c*B + p/S] : chn[c][p-1];
      @(posedge clk); #1;
      shift_en = 1'b0;
      for (int c = 0; c < N; c++) chn[c] = nxt[c];
    end
    #1;
    chk(done == 1'b1, {"R7 done after e2e ", tag}, 32'(done), 32'd1);
    for (int c = 0; c < N; c++)
      chk(chn[c] == '0, {"R9 chains zero ", tag}, 32'(chn[c]), 32'd0);
    model_en = 1'b0;
  endtask

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; shift_en = 1'b0;
    sweep_tap = '0; model_en = 1'b0;
    for (int c = 0; c < N; c++) begin chn[c] = '0; orig[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); sweep_tap = '1; #1;
    // R1: reset state
    chk(!done && !cmp_bit && !scan_out && seg_fill == '0, "R1 reset",
        {done, cmp_bit, scan_out, 1'b0, seg_fill}, 32'd0);

    // R2 R3: exhaustive taps in first block, counter paused (R6)
    pulse_start();
    sweep_compact("R2/R3 compact sweep");

    // R6: one short of the block boundary, then pause
    shift(S - 1);
    repeat (5) @(posedge clk);
    @(negedge clk); sweep_tap = '1; #1;
    chk(scan_out == 1'b0 && cmp_bit == (T % 2), "R6 paused in block 0",
        {scan_out, cmp_bit}, {1'b0, 1'(T % 2)});
    shift(1);
    // R4 R5: exhaustive taps in a drain block
    sweep_drain("R4/R5 drain sweep");

    // R7: done after exactly L shifts
    shift(L - S - 1);
    #1 chk(done == 1'b0, "R7 not done at L-1", 32'(done), 32'd0);
    shift(1);
    @(negedge clk); sweep_tap = '1; #1;
    chk(done == 1'b1, "R7 done at L", 32'(done), 32'd1);
    chk(!cmp_bit && !scan_out && seg_fill == '0, "R7 idle outputs",
        {cmp_bit, scan_out, 2'b00, seg_fill}, 32'd0);
    repeat (4) @(posedge clk);
    #1 chk(done == 1'b1, "R7 done holds", 32'(done), 32'd1);
    shift(3);
    #1 chk(done == 1'b1 && !scan_out, "R7 shifts ignored when done", {done, scan_out}, 32'd2);

    // R8: restart in mid-drain
    pulse_start();
    #1 chk(done == 1'b0, "R8 start clears done", 32'(done), 32'd0);
    shift(S + 2);
    @(negedge clk); sweep_tap = '0; sweep_tap[TAIL] = 1'b1; #1;
    chk(scan_out == 1'b1, "R8 in drain before restart", 32'(scan_out), 32'd1);
    @(negedge clk); start = 1'b1; shift_en = 1'b1;
    @(posedge clk); #1 start = 1'b0; shift_en = 1'b0;
    @(negedge clk); sweep_tap = 12'h001; #1;
    chk(cmp_bit == 1'b1 && scan_out == 1'b0, "R8 back in block 0",
        {cmp_bit, scan_out}, 32'd2);
    shift(L - 1);
    #1 chk(done == 1'b0, "R8 full count after restart (L-1)", 32'(done), 32'd0);
    shift(1);
    #1 chk(done == 1'b1, "R8 full count after restart (L)", 32'(done), 32'd1);

    // R9: end to end unloads
    for (int c = 0; c < N; c++) orig[c] = '0;
    run_e2e("zeros");
    for (int c = 0; c < N; c++) orig[c] = '1;
    run_e2e("ones");
    for (int w = 0; w < N * L; w += 5) begin
      for (int c = 0; c < N; c++) orig[c] = '0;
      orig[w / L][w % L] = 1'b1;
      run_e2e("walk");
    end
    for (int r = 0; r < 24; r++) begin
      for (int c = 0; c < N; c++) begin
        for (int p = 0; p < L; p++) begin
          lfsr = lfsr_step(lfsr);
          orig[c][p] = lfsr[0];
        end
      end
      run_e2e("random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule